// File: doc/BRIEF.md
# Resolver Signal Fault Monitor

This block watches the demodulated sine and cosine amplitude samples of a resolver front end, together with the tracking-loop error and the reference phase error. Every clock it compares them against five programmable thresholds. Two active-low pins show live conditions. One pin reports a degraded signal (an amplitude above its limit, or sine and cosine that disagree). The other reports loss of tracking. An 8-bit fault register gathers every condition seen and presents a snapshot of them to the host at each falling edge of the sample strobe.

Thresholds are written through a small address/data port. All comparisons are unsigned and work on magnitudes: the signed inputs are first turned into their two's-complement absolute values. The host reads the fault register when it likes. A read pulse marks the collected history as consumed, so the snapshot that follows reflects only new conditions. Without a read, a bit that was set stays set in every later snapshot.

Top module: `resolver_fault_mon`

## Requirements
- R1: After reset both status pins are high and the fault register is 0x00. Every threshold resets to mid-scale, 2^(W-1) (2048 for W=12).
- R2: The magnitude of a signed input is its two's-complement absolute value, and -2^(W-1) gives 2^(W-1). Fault bit 1 flags a sine magnitude strictly below the loss threshold. Fault bit 2 flags a cosine magnitude strictly below the loss threshold.
- R3: Fault bit 3 flags a sine magnitude strictly above the over-range threshold. Fault bit 4 flags the same condition for cosine.
- R4: Fault bit 5 flags an absolute difference between the sine and cosine magnitudes that is strictly above the mismatch threshold.
- R5: Fault bit 6 flags a tracking-error magnitude strictly above the tracking threshold. track_lost_no is low exactly in the cycle after such a sample and is not latched.
- R6: Fault bit 7 flags a phase-error magnitude strictly above the phase threshold.
- R7: Fault bit 0 flags a sine or cosine sample at either rail: +2^(W-1)-1 or -2^(W-1).
- R8: sig_degraded_no is low in the cycle after a sample that raises bit 3, 4 or 5. It is not latched, and a loss-of-signal condition on its own does not pull it low.
- R9: fault_o loads only on the clock edge at which a high-to-low change of sample_i is first seen. It holds its value through any other cycle, including the rising edge of the strobe.
- R10: Flags collect without clearing, so a bit set since the last read appears in every later snapshot. A fault_rd_i pulse reloads the collection with only the flags live in that cycle, and the next snapshot holds only flags seen from then on.
- R11: A write with cfg_we_i high sets a threshold. Address 0 is loss, 1 is over-range, 2 is mismatch, 3 is tracking and 4 is phase. Writes to addresses 5 to 7 change nothing. A new threshold takes effect for samples compared in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sin_i | input | W | Signed sine amplitude sample |
| cos_i | input | W | Signed cosine amplitude sample |
| trk_err_i | input | W | Signed tracking-loop error |
| ph_err_i | input | W | Signed reference phase error |
| cfg_we_i | input | 1 | Threshold write enable |
| cfg_addr_i | input | 3 | Threshold select |
| cfg_data_i | input | W | Threshold value |
| sample_i | input | 1 | Sample strobe; falling edge takes a snapshot |
| fault_rd_i | input | 1 | Host read pulse; restarts the collection |
| sig_degraded_no | output | 1 | Live over-range or mismatch, active low |
| track_lost_no | output | 1 | Live tracking loss, active low |
| fault_o | output | 8 | Snapshot fault register |

## Verification
The comparator flags sit behind a single register. Each status pin therefore follows its input sample one clock edge later, and the bench drives on a falling clock edge and reads at the next falling edge. A snapshot needs the strobe to be seen high at one edge and low at the next, so the bench reads fault_o one edge after it drops sample_i. The bench checks that fault_o is unchanged at every step before that edge. Each threshold write is checked at two edges: the write edge still compares against the old value, and the edge after it uses the new one.

// File: rtl/rfm_pkg.sv
`timescale 1ns/1ps
package rfm_pkg;
  localparam int N_THR = 5;
  localparam int FLT_W = 8;
  localparam int N_MAG = 4;

  typedef enum logic [2:0] {
    THR_LOS = 3'd0,
    THR_OVR = 3'd1,
    THR_MM  = 3'd2,
    THR_TRK = 3'd3,
    THR_PH  = 3'd4
  } thr_sel_e;

  localparam int B_CLIP  = 0;
  localparam int B_LOS_S = 1;
  localparam int B_LOS_C = 2;
  localparam int B_OVR_S = 3;
  localparam int B_OVR_C = 4;
  localparam int B_MM    = 5;
  localparam int B_TRK   = 6;
  localparam int B_PH    = 7;
endpackage

// File: rtl/rfm_mag.sv
`timescale 1ns/1ps
module rfm_mag #(
  parameter int W = 12
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] mag_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] neg;
  assign neg   = ~x_i + ONE;
  assign mag_o = x_i[W-1] ? neg : x_i;
endmodule

// File: rtl/rfm_thr_regs.sv
`timescale 1ns/1ps
module rfm_thr_regs
  import rfm_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] thr_o [N_THR]
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    logic [W-1:0] thr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        thr_q <= MID;
      else if (we_i && addr_i == 3'(g))   thr_q <= data_i;
    end
    assign thr_o[g] = thr_q;
  end
endmodule

// File: rtl/rfm_compare.sv
`timescale 1ns/1ps
module rfm_compare
  import rfm_pkg::*;
#(
  parameter int W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     sin_i,
  input  logic [W-1:0]     cos_i,
  input  logic [W-1:0]     trk_i,
  input  logic [W-1:0]     ph_i,
  input  logic [W-1:0]     thr_i [N_THR],
  output logic [FLT_W-1:0] live_o
);
  localparam logic [W-1:0] POS_RAIL = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_RAIL = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] raw [N_MAG];
  logic [W-1:0] mag [N_MAG];
  assign raw[0] = sin_i;
  assign raw[1] = cos_i;
  assign raw[2] = trk_i;
  assign raw[3] = ph_i;

  for (genvar g = 0; g < N_MAG; g++) begin : g_mag
    rfm_mag #(.W(W)) u_mag (.x_i(raw[g]), .mag_o(mag[g]));
  end

  logic [W-1:0]     diff;
  logic             sin_rail, cos_rail;
  logic [FLT_W-1:0] flags;

  assign diff     = (mag[0] >= mag[1]) ? (mag[0] - mag[1]) : (mag[1] - mag[0]);
  assign sin_rail = (sin_i == POS_RAIL) || (sin_i == NEG_RAIL);
  assign cos_rail = (cos_i == POS_RAIL) || (cos_i == NEG_RAIL);

  always_comb begin
    flags          = '0;
    flags[B_CLIP]  = sin_rail | cos_rail;
    flags[B_LOS_S] = mag[0] < thr_i[THR_LOS];
    flags[B_LOS_C] = mag[1] < thr_i[THR_LOS];
    flags[B_OVR_S] = mag[0] > thr_i[THR_OVR];
    flags[B_OVR_C] = mag[1] > thr_i[THR_OVR];
    flags[B_MM]    = diff   > thr_i[THR_MM];
    flags[B_TRK]   = mag[2] > thr_i[THR_TRK];
    flags[B_PH]    = mag[3] > thr_i[THR_PH];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_o <= '0;
    else         live_o <= flags;
  end
endmodule

// File: rtl/rfm_fault_reg.sv
`timescale 1ns/1ps
module rfm_fault_reg
  import rfm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FLT_W-1:0] live_i,
  input  logic             sample_i,
  input  logic             rd_i,
  output logic [FLT_W-1:0] fault_o
);
  logic             sample_q;
  logic [FLT_W-1:0] hold_q, fault_q;
  logic             fall;

  assign fall = sample_q & ~sample_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= 1'b0;
      hold_q   <= '0;
      fault_q  <= '0;
    end else begin
      sample_q <= sample_i;
      // read restarts collection from the flags live now
      hold_q   <= rd_i ? live_i : (hold_q | live_i);
      if (fall) fault_q <= hold_q | live_i;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/resolver_fault_mon.sv
`timescale 1ns/1ps
module resolver_fault_mon
  import rfm_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sin_i,
  input  logic [W-1:0] cos_i,
  input  logic [W-1:0] trk_err_i,
  input  logic [W-1:0] ph_err_i,
  input  logic         cfg_we_i,
  input  logic [2:0]   cfg_addr_i,
  input  logic [W-1:0] cfg_data_i,
  input  logic         sample_i,
  input  logic         fault_rd_i,
  output logic         sig_degraded_no,
  output logic         track_lost_no,
  output logic [7:0]   fault_o
);
  logic [W-1:0]     thr [N_THR];
  logic [FLT_W-1:0] live;
  logic [W-1:0]     thr_ovr, thr_trk;

  rfm_thr_regs #(.W(W)) u_thr (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .data_i(cfg_data_i),
    .thr_o(thr)
  );

  rfm_compare #(.W(W)) u_cmp (
    .clk_i, .rst_ni,
    .sin_i, .cos_i, .trk_i(trk_err_i), .ph_i(ph_err_i),
    .thr_i(thr), .live_o(live)
  );

  rfm_fault_reg u_freg (
    .clk_i, .rst_ni,
    .live_i(live), .sample_i, .rd_i(fault_rd_i),
    .fault_o
  );

  assign thr_ovr         = thr[THR_OVR];
  assign thr_trk         = thr[THR_TRK];
  assign sig_degraded_no = ~(live[B_OVR_S] | live[B_OVR_C] | live[B_MM]);
  assign track_lost_no   = ~live[B_TRK];
endmodule

// File: rtl/resolver_fault_mon_chk.sv
`timescale 1ns/1ps
module resolver_fault_mon_chk #(
  parameter int W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] sin_i,
  input logic [W-1:0] trk_err_i,
  input logic         cfg_we_i,
  input logic [2:0]   cfg_addr_i,
  input logic [W-1:0] cfg_data_i,
  input logic         sample_i,
  input logic [7:0]   live,
  input logic [W-1:0] thr_ovr,
  input logic [W-1:0] thr_trk,
  input logic         sig_degraded_no,
  input logic         track_lost_no,
  input logic [7:0]   fault_o
);
  logic         smp_d;
  logic [W-1:0] m_trk, m_sin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_d <= 1'b0;
    else         smp_d <= sample_i;
  end

  assign m_trk = trk_err_i[W-1] ? (~trk_err_i + 1'b1) : trk_err_i;
  assign m_sin = sin_i[W-1]     ? (~sin_i + 1'b1)     : sin_i;

  p_hold_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smp_d && !sample_i) |=> $stable(fault_o));

  p_snap_live_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_d && !sample_i) |=> ((fault_o & $past(live)) == $past(live)));

  p_trk_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_trk > thr_trk) |=> !track_lost_no);

  p_trk_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_trk <= thr_trk) |=> track_lost_no);

  p_ovr_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_sin > thr_ovr) |=> !sig_degraded_no);

  p_cfg_trk_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == 3'd3) |=> (thr_trk == $past(cfg_data_i)));
endmodule

bind resolver_fault_mon resolver_fault_mon_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .sin_i, .trk_err_i, .cfg_we_i, .cfg_addr_i, .cfg_data_i,
  .sample_i, .live, .thr_ovr, .thr_trk, .sig_degraded_no, .track_lost_no, .fault_o
);

// File: tb/tb_resolver_fault_mon.sv
`timescale 1ns/1ps
module tb_resolver_fault_mon;
  localparam int W  = 12;
  localparam int NV = 13;

  localparam int V_SIN [NV] = '{1000, 300, 1000, 1900, 2047, -2048, 1000, 1000, 1000, 400, 399, 1000, 1000};
  localparam int V_COS [NV] = '{1000, 1000, -350, -1850, 1900, 1900, 1000, 1000, 1000, 400, 1800, 1300, 1301};
  localparam int V_TRK [NV] = '{0, 0, 0, 0, 0, 0, -150, 100, 0, 0, 0, 0, 0};
  localparam int V_PH  [NV] = '{0, 0, 0, 0, 0, 0, 0, -201, 200, 0, 0, 0, 0};
  localparam int V_FLG [NV] = '{'h00, 'h22, 'h24, 'h18, 'h19, 'h19, 'h40, 'h80, 'h00, 'h00, 'h22, 'h00, 'h20};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [W-1:0] sin_v = '0, cos_v = '0, trk_v = '0, ph_v = '0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_addr = '0;
  logic [W-1:0] cfg_data = '0;
  logic         sample = 1'b0, rd = 1'b0;
  logic         degr_n, trk_n;
  logic [7:0]   fault;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  resolver_fault_mon #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sin_i(sin_v), .cos_i(cos_v), .trk_err_i(trk_v), .ph_err_i(ph_v),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .sample_i(sample), .fault_rd_i(rd),
    .sig_degraded_no(degr_n), .track_lost_no(trk_n), .fault_o(fault)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_data = W'(d);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic drive(int s, int c, int t, int p);
    sin_v = W'(s); cos_v = W'(c); trk_v = W'(t); ph_v = W'(p);
  endtask

  task automatic strobe();
    sample = 1'b1; step();
    sample = 1'b0; step();
  endtask

  task automatic read_strobe();
    rd = 1'b1; step();
    rd = 1'b0;
    strobe();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    drive(1000, 1000, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 fault reg after reset", 32'(fault), 0);
    chk("R1 degraded pin after reset", 32'(degr_n), 1);
    chk("R1 track pin after reset", 32'(trk_n), 1);

    // R11 writes to unused addresses change nothing; R1 mid-scale defaults
    wr(5, 0); wr(6, 0); wr(7, 0);
    drive(1000, 1000, 5, 5);
    step();
    read_strobe();
    chk("R1 R11 default thresholds, unused addresses ignored", 32'(fault), 'h06);
    chk("R1 degraded pin with defaults", 32'(degr_n), 1);
    chk("R1 track pin with defaults", 32'(trk_n), 1);

    // R11 threshold takes effect one cycle after its write edge
    drive(1000, 1000, 150, 0);
    wr(3, 100);
    chk("R11 write edge uses old threshold", 32'(trk_n), 1);
    step();
    chk("R11 new threshold active next cycle", 32'(trk_n), 0);

    wr(0, 400); wr(1, 1800); wr(2, 300); wr(4, 200);

    // table of vectors (R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < NV; i++) begin
      logic [7:0] f;
      f = 8'(V_FLG[i]);
      drive(V_SIN[i], V_COS[i], V_TRK[i], V_PH[i]);
      step();
      chk($sformatf("R8 degraded pin vec %0d", i), 32'(degr_n), 32'(!(f[3] | f[4] | f[5])));
      chk($sformatf("R5 track pin vec %0d", i), 32'(trk_n), 32'(!f[6]));
      read_strobe();
      chk($sformatf("R2 R3 R4 R6 R7 snapshot vec %0d", i), 32'(fault), 32'(f));
    end

    // R5 / R8 not latched
    drive(1000, 1000, -150, 0); step();
    chk("R5 track pin low on error", 32'(trk_n), 0);
    drive(1000, 1000, 0, 0); step();
    chk("R5 track pin released", 32'(trk_n), 1);
    drive(1900, 1000, 0, 0); step();
    chk("R8 degraded pin low", 32'(degr_n), 0);
    drive(1000, 1000, 0, 0); step();
    chk("R8 degraded pin released", 32'(degr_n), 1);
    drive(100, 100, 0, 0); step();
    chk("R8 loss of signal alone keeps pin high", 32'(degr_n), 1);

    // clear history
    drive(1000, 1000, 0, 0); step();
    read_strobe();
    chk("R10 cleared baseline", 32'(fault), 0);

    // R9 no snapshot without a falling strobe
    drive(300, 1000, 0, 0); step(); step(); step();
    chk("R9 register holds without strobe", 32'(fault), 0);
    drive(1000, 1000, 0, 0); step(); step();
    sample = 1'b1; step();
    chk("R9 rising strobe does not load", 32'(fault), 0);
    sample = 1'b0; step();
    chk("R10 sticky bits captured after fault left", 32'(fault), 'h22);
    strobe();
    chk("R10 bits stay without a read", 32'(fault), 'h22);
    read_strobe();
    chk("R10 read clears at next snapshot", 32'(fault), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule